// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits on the memory side of a small shared word store. It lets several requesters perform indivisible read-modify-write operations, which software uses to build locks, counters and semaphores. Each requester has its own request line and operand fields. A round-robin arbiter picks one request at a time. The unit then holds that grant through a private read step and a write step, so no other access can fall between the read and the write. When the write step completes, the unit returns the word that was in memory before the operation, together with a status bit.

Plain loads and stores go through the same sequence as the atomic operations. The unit supports test-and-set, fetch-and-add, swap and compare-and-swap. The storage is an internal register array that is cleared on reset.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, every memory word reads as 0. No grant and no response valid is asserted until a request arrives.
- R2: Opcode 0 (load) returns the addressed word, leaves memory unchanged and reports status 1. The unused codes 6 and 7 behave exactly like a load.
- R3: Opcode 1 (store) writes operand A to the addressed word, returns the previous word and reports status 1.
- R4: Opcode 2 (test-and-set) returns the previous word. It writes 1 only when that previous word was 0, and otherwise leaves the word unchanged. Status is 1.
- R5: Opcode 3 (fetch-and-add) returns the previous word and writes the previous word plus operand A, modulo 2^DATA_W, with no overflow indication. Status is 1.
- R6: Opcode 4 (swap) writes operand A, returns the previous word and reports status 1.
- R7: Opcode 5 (compare-and-swap) compares the word with operand A. When they are equal, it writes operand B and reports status 1. When they differ, it leaves memory unchanged and reports status 0. In both cases it returns the previous word. Status 0 occurs for no other case.
- R8: At most one grant line is high at a time. A pending request that the idle unit samples on a clock edge sees its grant high for the next two cycles. Its response valid line pulses for exactly one cycle, in the second of those cycles, with the old word and the status on the shared response fields.
- R9: Arbitration is round robin. After requester k has been served, the next grant goes to the first pending requester found by searching from k+1 upward, wrapping around. After reset the search starts at requester 0.
- R10: When several requesters contend for the same word, their operations are serialized. Each operation reads the value left by the operation before it. Concurrent fetch-and-adds therefore lose no increment, and only one concurrent test-and-set observes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_REQ | Per-requester request. A requester holds it, with its fields stable, until its response. |
| op_i | input | N_REQ x 3 | Per-requester opcode |
| addr_i | input | N_REQ x ADDR_W | Per-requester word address |
| opa_i | input | N_REQ x DATA_W | Operand A: store, swap or add value, or the compare-and-swap expected value |
| opb_i | input | N_REQ x DATA_W | Operand B: the compare-and-swap new value |
| gnt_o | output | N_REQ | One-hot grant, held for the whole read-then-write sequence |
| rsp_valid_o | output | N_REQ | One-cycle response pulse on the owner's line |
| rsp_data_o | output | DATA_W | Word held before the operation |
| rsp_ok_o | output | 1 | Status; 0 only for a failed compare-and-swap |

## Verification
The bench builds the unit with its defaults: three requesters, 16-bit words and eight locations. With three requesters, a three-way tie can be resolved in both rotation orders, so the round-robin pointer is observed wrapping. With 16-bit words, a fetch-and-add wraparound and distinctive patterns (0xBEEF, 0xA5A5) can be checked exactly. Eight locations let each operation class use its own address, so one class cannot disturb another. Contention tests put all requesters on one word, first with fetch-and-add and then with test-and-set, to show that the operations are serialized.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_TAS   = 3'd2;
  localparam logic [2:0] OP_FAA   = 3'd3;
  localparam logic [2:0] OP_SWAP  = 3'd4;
  localparam logic [2:0] OP_CAS   = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N_REQ = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             advance_i,
  output logic [N_REQ-1:0] pick_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    pick_o     = '0;
    pick_idx_o = '0;
    for (int k = N_REQ; k >= 1; k--) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (req_i[idx]) begin
        pick_o     = '0;
        pick_o[idx] = 1'b1;
        pick_idx_o = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IDX_W'(N_REQ - 1);
    else if (advance_i && |req_i) last_q <= pick_idx_o;
  end

  assert_pick_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> ($onehot(pick_o) && ((pick_o & ~req_i) == '0)));
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] new_o,
  output logic              we_o,
  output logic              ok_o
);
  always_comb begin
    new_o = old_i;
    we_o  = 1'b0;
    ok_o  = 1'b1;
    case (op_i)
      OP_STORE: begin we_o = 1'b1; new_o = opa_i; end
      OP_TAS: begin
        if (old_i == '0) begin we_o = 1'b1; new_o = DATA_W'(1); end
      end
      OP_FAA:  begin we_o = 1'b1; new_o = old_i + opa_i; end
      OP_SWAP: begin we_o = 1'b1; new_o = opa_i; end
      OP_CAS: begin
        if (old_i == opa_i) begin we_o = 1'b1; new_o = opb_i; end
        else ok_o = 1'b0;
      end
      default: ;  // load and unused codes: read only
    endcase
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int N_REQ  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_i,
  input  logic [N_REQ-1:0][2:0]         op_i,
  input  logic [N_REQ-1:0][ADDR_W-1:0]  addr_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  opa_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  opb_i,
  output logic [N_REQ-1:0]              gnt_o,
  output logic [N_REQ-1:0]              rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_data_o,
  output logic                          rsp_ok_o
);
  seq_state_e        state_q;
  logic [N_REQ-1:0]  owner_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q;

  logic              accept;
  logic [N_REQ-1:0]  pick;
  logic [IDX_W-1:0]  pick_idx;
  logic [DATA_W-1:0] rd_data, new_val;
  logic              alu_we, alu_ok, mem_we;

  assign accept = (state_q == ST_IDLE) && (|req_i);

  rr_arbiter #(.N_REQ(N_REQ)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .advance_i  (accept),
    .pick_o     (pick),
    .pick_idx_o (pick_idx)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_q),
    .old_i (old_q),
    .opa_i (opa_q),
    .opb_i (opb_q),
    .new_o (new_val),
    .we_o  (alu_we),
    .ok_o  (alu_ok)
  );

  assign mem_we = (state_q == ST_WR) && alu_we;

  word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_q),
    .we_i    (mem_we),
    .wdata_i (new_val),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      old_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          owner_q <= pick;
          op_q    <= op_i[pick_idx];
          addr_q  <= addr_i[pick_idx];
          opa_q   <= opa_i[pick_idx];
          opb_q   <= opb_i[pick_idx];
          state_q <= ST_RD;
        end
        ST_RD: begin
          old_q   <= rd_data;
          state_q <= ST_WR;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_o       = (state_q != ST_IDLE) ? owner_q : '0;
  assign rsp_valid_o = (state_q == ST_WR) ? owner_q : '0;
  assign rsp_data_o  = old_q;
  assign rsp_ok_o    = alu_ok;

  assert_single_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_grant_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |=> ($stable(gnt_o) && (|rsp_valid_o)));
  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rsp_valid_o) |=> !(|rsp_valid_o));
  assert_rsp_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rsp_valid_o) |-> (rsp_valid_o == gnt_o));
  assert_fail_only_cas_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rsp_valid_o) && !rsp_ok_o) |-> (op_q == OP_CAS && !mem_we));
  assert_load_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rsp_valid_o) && (op_q == OP_LOAD || op_q > OP_CAS)) |-> !mem_we);
  assert_write_in_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (|rsp_valid_o));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int N = 3;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0][2:0] op = '0;
  logic [N-1:0][AW-1:0] addr = '0;
  logic [N-1:0][DW-1:0] opa = '0, opb = '0;
  logic [N-1:0] gnt, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic rsp_ok;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.N_REQ(N), .DATA_W(DW), .ADDR_W(AW)) u_atomic_rmw_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .opa_i(opa), .opb_i(opb), .gnt_o(gnt), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .rsp_ok_o(rsp_ok)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
    logic        ok;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd0, 3'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1},  // R2
    '{4'd3,  3'd1, 3'd0, 16'h1234, 16'h0000, 16'h0000, 1'b1},  // R3
    '{4'd3,  3'd0, 3'd0, 16'h0000, 16'h0000, 16'h1234, 1'b1},
    '{4'd4,  3'd2, 3'd1, 16'h0000, 16'h0000, 16'h0000, 1'b1},  // R4
    '{4'd4,  3'd2, 3'd1, 16'h0000, 16'h0000, 16'h0001, 1'b1},
    '{4'd4,  3'd0, 3'd1, 16'h0000, 16'h0000, 16'h0001, 1'b1},
    '{4'd5,  3'd3, 3'd2, 16'hFFFE, 16'h0000, 16'h0000, 1'b1},  // R5
    '{4'd5,  3'd3, 3'd2, 16'h0003, 16'h0000, 16'hFFFE, 1'b1},
    '{4'd5,  3'd0, 3'd2, 16'h0000, 16'h0000, 16'h0001, 1'b1},
    '{4'd6,  3'd4, 3'd3, 16'hBEEF, 16'h0000, 16'h0000, 1'b1},  // R6
    '{4'd6,  3'd4, 3'd3, 16'h0042, 16'h0000, 16'hBEEF, 1'b1},
    '{4'd7,  3'd5, 3'd3, 16'h1111, 16'h2222, 16'h0042, 1'b0},  // R7
    '{4'd7,  3'd0, 3'd3, 16'h0000, 16'h0000, 16'h0042, 1'b1},
    '{4'd7,  3'd5, 3'd3, 16'h0042, 16'h7777, 16'h0042, 1'b1},
    '{4'd7,  3'd0, 3'd3, 16'h0000, 16'h0000, 16'h7777, 1'b1},
    '{4'd2,  3'd6, 3'd3, 16'h9999, 16'h9999, 16'h7777, 1'b1},
    '{4'd2,  3'd7, 3'd3, 16'h5555, 16'h5555, 16'h7777, 1'b1},
    '{4'd3,  3'd1, 3'd7, 16'hA5A5, 16'h0000, 16'h0000, 1'b1},
    '{4'd4,  3'd2, 3'd7, 16'h0000, 16'h0000, 16'hA5A5, 1'b1},
    '{4'd4,  3'd0, 3'd7, 16'h0000, 16'h0000, 16'hA5A5, 1'b1}
  };

  task automatic check(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input int r, input int tag, input logic [2:0] o, input logic [AW-1:0] ad,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] exp, input logic exp_ok);
    bit seen = 0;
    @(negedge clk);
    op[r] = o; addr[r] = ad; opa[r] = a; opb[r] = b; req[r] = 1'b1;
    for (int c = 0; c < 50 && !seen; c++) begin
      @(negedge clk);
      if (rsp_valid[r]) begin
        seen = 1;
        check(tag, "data", 32'(rsp_data), 32'(exp));
        check(tag, "status", 32'(rsp_ok), 32'(exp_ok));
        req[r] = 1'b0;
      end
    end
    if (!seen) check(tag, "no response", 32'd0, 32'd1);
  endtask

  int ord_q [N];
  logic [DW-1:0] got_q [N];

  task automatic contest(input logic [2:0] o, input logic [AW-1:0] ad, input logic [DW-1:0] a);
    int seen = 0;
    @(negedge clk);
    for (int r = 0; r < N; r++) begin
      op[r] = o; addr[r] = ad; opa[r] = a; opb[r] = '0;
    end
    req = '1;
    for (int c = 0; c < 40 && seen < N; c++) begin
      @(negedge clk);
      for (int r = 0; r < N; r++) begin
        if (rsp_valid[r] && seen < N) begin
          ord_q[seen] = r;
          got_q[seen] = rsp_data;
          seen++;
          req[r] = 1'b0;
        end
      end
    end
    req = '0;
    if (seen != N) check(10, "contest incomplete", 32'(seen), 32'(N));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=response");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(1, "grant after reset", 32'(gnt), 32'd0);
    check(1, "valid after reset", 32'(rsp_valid), 32'd0);
    do_op(1, 1, 3'd0, 3'd6, '0, '0, 16'h0000, 1'b1);  // R1 cleared word

    // R8: grant and response timing
    @(negedge clk);
    op[0] = 3'd0; addr[0] = 3'd0; req[0] = 1'b1;
    @(negedge clk);
    check(8, "grant cycle 1", 32'(gnt), 32'b001);
    check(8, "valid cycle 1", 32'(rsp_valid), 32'b000);
    @(negedge clk);
    check(8, "grant cycle 2", 32'(gnt), 32'b001);
    check(8, "valid cycle 2", 32'(rsp_valid), 32'b001);
    req[0] = 1'b0;
    @(negedge clk);
    check(8, "grant released", 32'(gnt), 32'b000);
    check(8, "valid one cycle", 32'(rsp_valid), 32'b000);

    // vector table: R2 to R7
    for (int i = 0; i < NV; i++)
      do_op(i % N, int'(VECS[i].tag), VECS[i].op, VECS[i].addr, VECS[i].a, VECS[i].b,
            VECS[i].exp, VECS[i].ok);

    // R9, R10: serve requester 2 last, so a tie resolves 0,1,2
    do_op(2, 9, 3'd0, 3'd4, '0, '0, 16'h0000, 1'b1);
    contest(3'd3, 3'd5, 16'h0001);
    for (int k = 0; k < N; k++) begin
      check(9, "rr order after 2", 32'(ord_q[k]), 32'(k));
      check(10, "faa serialized", 32'(got_q[k]), 32'(k));
    end
    do_op(0, 10, 3'd0, 3'd5, '0, '0, 16'h0003, 1'b1);

    // requester 0 served last: tie resolves 1,2,0; one TAS winner
    contest(3'd2, 3'd6, 16'h0000);
    check(9, "rr first after 0", 32'(ord_q[0]), 32'd1);
    check(9, "rr second after 0", 32'(ord_q[1]), 32'd2);
    check(9, "rr wrap after 0", 32'(ord_q[2]), 32'd0);
    check(10, "tas winner", 32'(got_q[0]), 32'd0);
    check(10, "tas loser a", 32'(got_q[1]), 32'd1);
    check(10, "tas loser b", 32'(got_q[2]), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule